// File: doc/BRIEF.md
# Line-Rate Interrupt Timer

This block is an 8-bit up-counting interrupt timer for a cartridge-side memory controller. It advances on CPU cycles, qualified by a clock enable, and runs in one of two modes. In line mode a signed prescaler approximates one count per video line: it removes 3 CPU-to-dot units each CPU cycle out of a 341-unit budget. In cycle mode the counter advances on every enabled CPU cycle.

Software programs it through three write targets: a reload value, a control byte and an acknowledge. The upstream address decoder picks the target and gives it as a 2-bit sub-index together with a write strobe. When the counter wraps past its top value it reloads and raises a level interrupt. The interrupt stays high until software writes the control byte or the acknowledge. The live count is brought out for debug.

Top module: `line_irq_timer`

## Requirements
- R1: A write with sub-index 0 stores `wr_data` as the reload value. A wrap in the same cycle still reloads the value that was held before that write.
- R2: A write with sub-index 1 stores control bits 2:0 and ignores the higher data bits. Bit 0 is run-after-ack, bit 1 is run and bit 2 is cycle mode. If bit 1 of the written data is 1, the count takes the reload value and the prescaler takes 341 on that edge. The write always clears the interrupt.
- R3: A write with sub-index 2 clears the interrupt and copies control bit 0 into control bit 1. Bits 0 and 2 keep their values.
- R4: In line mode (bit 2 = 0), each enabled step subtracts 3 from the prescaler. When the result is zero or negative, 341 is added to it and the counter takes one step. After a load of 341, the steps fall on enabled cycles 114, 228 and 341, and the pattern then repeats.
- R5: In cycle mode (bit 2 = 1), every enabled step advances the counter and the prescaler keeps its value.
- R6: A counter step from 0xFF loads the reload value and sets `irq`. Any other counter step adds one.
- R7: `irq` stays set until a sub-index 1 or 2 write. A cycle that carries such a write takes no counter or prescaler step, so the write wins over a wrap in that cycle.
- R8: While `cpu_ce` is 0 or the run bit is 0, the count and the prescaler hold their values. Writes are accepted regardless of `cpu_ce`.
- R9: A write with sub-index 3 changes nothing.
- R10: A synchronous reset clears the reload value, the control bits, the count, the prescaler and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_ce | input | 1 | One-cycle CPU cycle enable |
| wr_stb | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target sub-index |
| wr_data | input | 8 | Write data |
| irq | output | 1 | Level interrupt request |
| count_dbg | output | 8 | Current counter value |

## Verification
The assertions assume that `wr_sel` and `wr_data` carry known values whenever `wr_stb` is high. They also assume that 341 fits in the positive range of the signed prescaler. The checks on holds and wraps further assume that at most one write target is acted on per cycle, which the single strobe and sub-index interface guarantees. The bench drives every input at the falling edge so that only settled, known values are sampled. Its random phase draws sub-indices only from the legal 0 to 3 range and masks the control data, so that both modes and the wrap-versus-write collisions occur often.

// File: rtl/lit_pkg.sv
package lit_pkg;

    // Write targets as decoded upstream
    typedef enum logic [1:0] {
        SEL_RELOAD = 2'd0,
        SEL_CTRL   = 2'd1,
        SEL_ACK    = 2'd2,
        SEL_NONE   = 2'd3
    } sel_e;

    // Control bits; positions follow the written data byte
    typedef struct packed {
        logic cyc_mode;       // bit 2
        logic run;            // bit 1
        logic run_after_ack;  // bit 0
    } ctrl_t;

    typedef struct packed {
        logic ld_reload;
        logic ld_ctrl;
        logic ack;
    } wr_dec_t;

    function automatic wr_dec_t decode_write(input logic stb, input logic [1:0] sel);
        wr_dec_t d;
        d.ld_reload = stb && (sel_e'(sel) == SEL_RELOAD);
        d.ld_ctrl   = stb && (sel_e'(sel) == SEL_CTRL);
        d.ack       = stb && (sel_e'(sel) == SEL_ACK);
        return d;
    endfunction

endpackage

// File: rtl/lit_regs.sv
module lit_regs
    import lit_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_stb,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] reload_val,
    output ctrl_t         ctrl,
    output logic          load_cnt,
    output logic          clr_irq
);

    wr_dec_t dec;

    always_comb begin
        dec      = decode_write(wr_stb, wr_sel);
        load_cnt = dec.ld_ctrl && wr_data[1];
        clr_irq  = dec.ld_ctrl || dec.ack;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_val <= '0;
            ctrl       <= '0;
        end else begin
            if (dec.ld_reload)
                reload_val <= wr_data;
            if (dec.ld_ctrl)
                ctrl <= ctrl_t'(wr_data[2:0]);
            else if (dec.ack)
                ctrl.run <= ctrl.run_after_ack;
        end
    end

    // R1: stored reload value follows the written byte
    a_r1_reload_store: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_sel == 2'd0) |=> reload_val == $past(wr_data));

    // R3: acknowledge copies run-after-ack into run, leaves the rest
    a_r3_ack_copy: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_sel == 2'd2) |=>
            (ctrl.run == $past(ctrl.run_after_ack)) &&
            (ctrl.cyc_mode == $past(ctrl.cyc_mode)) &&
            (ctrl.run_after_ack == $past(ctrl.run_after_ack)));

    // R9: the unused target alters no register
    a_r9_unused_target: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_sel == 2'd3) |=> $stable(reload_val) && $stable(ctrl));

endmodule

// File: rtl/lit_prescaler.sv
module lit_prescaler #(
    parameter int PW     = 10,
    parameter int PERIOD = 341,
    parameter int STEP   = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic cyc_mode,
    input  logic load,
    output logic tick
);

    localparam logic signed [PW-1:0] PER_S  = PW'(PERIOD);
    localparam logic signed [PW-1:0] STEP_S = PW'(STEP);

    logic signed [PW-1:0] ps;
    logic signed [PW-1:0] ps_dec;
    logic                 expired;

    always_comb begin
        ps_dec  = ps - STEP_S;
        expired = ps_dec[PW-1] || (ps_dec == '0);
        tick    = step && (cyc_mode || expired);
    end

    always_ff @(posedge clk) begin
        if (rst)
            ps <= '0;
        else if (load)
            ps <= PER_S;
        else if (step && !cyc_mode)
            ps <= expired ? ps_dec + PER_S : ps_dec;
    end

    // R4: prescaler stays within 0..PERIOD
    a_r4_range: assert property (@(posedge clk) disable iff (rst)
        !ps[PW-1] && (ps <= PER_S));

    // R5: cycle mode leaves the prescaler untouched
    a_r5_ps_idle: assert property (@(posedge clk) disable iff (rst)
        (step && cyc_mode && !load) |=> $stable(ps));

    // R8: no step, no change
    a_r8_ps_hold: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> $stable(ps));

endmodule

// File: rtl/lit_counter.sv
module lit_counter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          load,
    input  logic          clr,
    input  logic [DW-1:0] reload_val,
    output logic [DW-1:0] count,
    output logic          irq
);

    logic wrap;

    always_comb wrap = tick && (count == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            irq   <= 1'b0;
        end else begin
            if (load)
                count <= reload_val;
            else if (tick)
                count <= wrap ? reload_val : count + 1'b1;

            if (clr)
                irq <= 1'b0;
            else if (wrap)
                irq <= 1'b1;
        end
    end

    // R6: a wrap reloads and raises the request
    a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
        (wrap && !load && !clr) |=> irq && (count == $past(reload_val)));

    // R6: the request only rises after a wrap
    a_r6_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(wrap));

    // R7: sticky until a clearing write
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr) |=> irq);

    // R7: clearing write wins
    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> !irq);

    // R8: count holds without tick or load
    a_r8_cnt_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(count));

endmodule

// File: rtl/line_irq_timer.sv
module line_irq_timer
    import lit_pkg::*;
#(
    parameter int DW     = 8,
    parameter int PW     = 10,
    parameter int PERIOD = 341,
    parameter int STEP   = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_ce,
    input  logic          wr_stb,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic          irq,
    output logic [DW-1:0] count_dbg
);

    logic [DW-1:0] reload_val;
    ctrl_t         ctrl;
    logic          load_cnt;
    logic          clr_irq;
    logic          step;
    logic          tick;

    lit_regs #(.DW(DW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_stb     (wr_stb),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .reload_val (reload_val),
        .ctrl       (ctrl),
        .load_cnt   (load_cnt),
        .clr_irq    (clr_irq)
    );

    // A clearing write suspends counting for its cycle
    always_comb step = cpu_ce && ctrl.run && !clr_irq;

    lit_prescaler #(.PW(PW), .PERIOD(PERIOD), .STEP(STEP)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .cyc_mode (ctrl.cyc_mode),
        .load     (load_cnt),
        .tick     (tick)
    );

    lit_counter #(.DW(DW)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .load       (load_cnt),
        .clr        (clr_irq),
        .reload_val (reload_val),
        .count      (count_dbg),
        .irq        (irq)
    );

    // R2: control write with run set loads the count
    a_r2_ctrl_load: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_sel == 2'd1 && wr_data[1]) |=> count_dbg == $past(reload_val));

    // R8: clock enable low freezes the count
    a_r8_ce_low: assert property (@(posedge clk) disable iff (rst)
        (!cpu_ce && !(wr_stb && wr_sel == 2'd1)) |=> $stable(count_dbg));

    // R10: reset leaves everything cleared
    a_r10_reset: assert property (@(posedge clk)
        rst |=> (count_dbg == '0) && !irq);

endmodule

// File: tb/line_irq_timer_test.sv
`timescale 1ns/1ps
module line_irq_timer_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       cpu_ce;
    logic       wr_stb;
    logic [1:0] wr_sel;
    logic [7:0] wr_data;
    logic       irq;
    logic [7:0] count_dbg;

    always #2.5 clk = ~clk;

    line_irq_timer uut (
        .clk       (clk),
        .rst       (rst),
        .cpu_ce    (cpu_ce),
        .wr_stb    (wr_stb),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .irq       (irq),
        .count_dbg (count_dbg)
    );

    typedef struct {
        logic       irq;
        logic [7:0] cnt;
        string      req;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    // Reference state, built from the requirements
    int m_reload, m_cnt, m_ps;
    bit m_cyc, m_run, m_raa, m_irq;

    task automatic cycle(input bit r, input bit ce, input bit stb,
                         input logic [1:0] sel, input logic [7:0] d, input string req);
        bit clr, stp, tk;
        int dec;
        exp_t e;
        @(negedge clk);
        rst = r; cpu_ce = ce; wr_stb = stb; wr_sel = sel; wr_data = d;
        if (r) begin
            m_reload = 0; m_cnt = 0; m_ps = 0;
            m_cyc = 0; m_run = 0; m_raa = 0; m_irq = 0;
        end else begin
            clr = stb && (sel == 2'd1 || sel == 2'd2);
            stp = ce && m_run && !clr;
            tk  = 0;
            if (stp) begin
                if (m_cyc) tk = 1;
                else begin
                    dec = m_ps - 3;
                    if (dec <= 0) begin m_ps = dec + 341; tk = 1; end
                    else m_ps = dec;
                end
            end
            if (tk) begin
                if (m_cnt == 255) begin m_cnt = m_reload; m_irq = 1; end
                else m_cnt = m_cnt + 1;
            end
            if (stb) begin
                case (sel)
                    2'd0: m_reload = d;
                    2'd1: begin
                        m_raa = d[0]; m_run = d[1]; m_cyc = d[2];
                        if (d[1]) begin m_cnt = m_reload; m_ps = 341; end
                        m_irq = 0;
                    end
                    2'd2: begin m_run = m_raa; m_irq = 0; end
                    default: ;
                endcase
            end
        end
        e.irq = m_irq; e.cnt = 8'(m_cnt); e.req = req;
        q.push_back(e);
    endtask

    task automatic idle(input int n, input bit ce, input string req);
        for (int i = 0; i < n; i++) cycle(0, ce, 0, 2'd0, 8'h00, req);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d, input string req);
        cycle(0, 1, 1, sel, d, req);
    endtask

    // Monitor: compares after each rising edge
    always begin
        @(posedge clk);
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_checks++;
            if (irq !== e.irq || count_dbg !== e.cnt) begin
                n_fail++;
                $display("FAIL %s: irq=%0b count=%02h, expected irq=%0b count=%02h",
                         e.req, irq, count_dbg, e.irq, e.cnt);
            end
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; cpu_ce = 0; wr_stb = 0; wr_sel = 0; wr_data = 0;
        // R10: reset state
        cycle(1, 0, 0, 2'd0, 8'h00, "R10 reset");
        cycle(1, 1, 1, 2'd1, 8'h06, "R10 reset");
        idle(3, 1, "R10 idle after reset");

        // R1, R2, R4, R6: line mode from reload FD, wraps after three line steps
        wr(2'd0, 8'hFD, "R1 reload write");
        wr(2'd1, 8'hFA, "R2 control run, upper bits ignored");
        idle(400, 1, "R4 line mode steps / R6 wrap");
        idle(150, 1, "R7 irq sticky");

        // R3: ack with run-after-ack clear stops counting
        wr(2'd2, 8'h00, "R3 ack clears irq and run");
        idle(200, 1, "R8 run clear holds count");

        // R5: cycle mode, reload F0 wraps every 16 steps
        wr(2'd0, 8'hF0, "R1 reload write");
        wr(2'd1, 8'h06, "R5 cycle mode load");
        idle(40, 1, "R5 cycle mode steps");

        // R8: clock enable low freezes everything
        idle(20, 0, "R8 cpu_ce low");
        for (int i = 0; i < 30; i++) cycle(0, i[0], 0, 2'd0, 8'h00, "R8 alternating cpu_ce");

        // R2: control write with run clear keeps count; R3 ack resumes from it
        wr(2'd1, 8'h05, "R2 control without run");
        idle(10, 1, "R8 held after control without run");
        wr(2'd2, 8'h00, "R3 ack sets run from bit 0");
        idle(20, 1, "R3 resumed counting");

        // R9: unused target has no effect
        wr(2'd3, 8'hFF, "R9 unused target");
        idle(20, 1, "R9 counting unchanged");

        // R7: ack lands exactly on the wrap cycle
        wr(2'd0, 8'hFE, "R1 reload write");
        wr(2'd1, 8'h07, "R2 reload FE cycle mode");
        idle(1, 1, "R7 approach wrap");
        wr(2'd2, 8'h00, "R7 ack on wrap cycle wins");
        idle(5, 1, "R7 after collision");

        // R1: reload write on the wrap cycle uses the old value
        wr(2'd1, 8'h07, "R2 reload");
        idle(1, 1, "R1 approach wrap");
        wr(2'd0, 8'h80, "R1 reload write during wrap");
        idle(10, 1, "R1 next reload uses new value");

        // R4: line mode entered through ack keeps the prescaler as left
        wr(2'd1, 8'h01, "R2 line mode, run clear");
        wr(2'd2, 8'h00, "R4 ack enables line mode");
        idle(800, 1, "R4 line mode after ack");

        // Random phase across all requirements
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 6)
                cycle(0, 1'($urandom_range(0, 1)), 1, 2'($urandom_range(0, 3)),
                      8'($urandom_range(0, 255)) | 8'h02, "R2 R3 R7 random write");
            else
                cycle(0, (r % 5) != 0, 0, 2'd0, 8'h00, "R4 R5 R6 R8 random run");
        end
        cycle(1, 1, 0, 2'd0, 8'h00, "R10 reset at end");
        idle(2, 1, "R10 post reset");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule